// File: doc/BRIEF.md
# Four-Moduli Residue-to-Binary Converter

This block rebuilds a binary integer from its four residues. The moduli are 2^q-1, 2^q+1, 2^q-3 and 2^q+3. The result lies between zero and one less than the product of the four moduli. The moduli are handled as two conjugate pairs, and each pair has its own first-stage unit.

The first unit merges the residues of 2^q-1 and 2^q+1 into a value modulo 2^(2q)-1. The second unit merges the residues of 2^q-3 and 2^q+3 into a value modulo 2^(2q)-9. A second stage then merges these two values into the final integer. Every constant multiplicative inverse is applied as a sum of shifted copies of the operand, so the datapath holds only adders, comparators and fixed wiring.

An elaboration parameter chooses between two timing modes. In one mode the path from input to output is purely combinational. In the other mode a register sits between the two stages, and the output appears one cycle after the strobe.

Top module: `rnsReverseConverter`

## Requirements
- R1: For every legal residue set of an integer X below the product of the moduli, `result` equals X. The integer used is the one whose residues are X mod (2^q-1) on `resMinusOne`, X mod (2^q+1) on `resPlusOne`, X mod (2^q-3) on `resMinusThree` and X mod (2^q+3) on `resPlusThree`.
- R2: With `PIPE_STAGE`=1, `outValid` is high exactly in the cycle after a clock edge that sampled `inValid` high. In that cycle `result` is the integer of the residues sampled at that edge.
- R3: With `PIPE_STAGE`=0, `outValid` equals `inValid` in the same cycle, and `result` is formed combinationally from the residues currently applied.
- R4: Whenever `outValid` is high, `result` is below (2^q-1)(2^q+1)(2^q-3)(2^q+3), which is 62985 for q=4.
- R5: On `resPlusOne`, a residue equal to 2^q (top bit set, all other bits clear) is converted correctly.
- R6: With `PIPE_STAGE`=1, after a clock edge that samples `inValid` low, `outValid` is low and `result` keeps its previous value, whatever residues are applied.
- R7: While `rstN` is low and after its release, until the first strobe, `outValid` is 0 and `result` is 0 (pipelined mode).
- R8: With `PIPE_STAGE`=1, strobes on consecutive cycles each produce their own correct result on consecutive cycles, with no bubble.
- R9: The end points X=0 and X=product-1 convert correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Residue set on the inputs is valid |
| resMinusOne | input | Q | Residue modulo 2^q-1 |
| resPlusOne | input | Q+1 | Residue modulo 2^q+1 |
| resMinusThree | input | Q | Residue modulo 2^q-3 |
| resPlusThree | input | Q+1 | Residue modulo 2^q+3 |
| outValid | output | 1 | `result` holds a converted integer |
| result | output | 4Q | Reconstructed binary integer |

## Verification
In pipelined mode, two things can happen in the same cycle: the stage register captures a new residue set, and the output presents the integer of the previous set. The bench provokes this by sweeping the whole dynamic range for q=4 with a strobe on every cycle. In each cycle it checks the output against the previous integer while the next one is being applied. Idle gaps are inserted at regular intervals, with unrelated legal residues on the inputs, to confirm that the held result and a low `outValid` are not disturbed by a capture that did not take place.

// File: rtl/rnsPkg.sv
`timescale 1ns/1ps
package rnsPkg;

  typedef struct packed {
    logic loadStage;
    logic outValid;
  } rnsCtrlT;

  // Inverse of a modulo m by the extended Euclidean algorithm, elaboration only.
  function automatic int modInverse(input int a, input int m);
    int t;
    int newT;
    int r;
    int newR;
    int qt;
    int tmp;
    t = 0;
    newT = 1;
    r = m;
    newR = a % m;
    for (int i = 0; i < 64; i++) begin
      if (newR != 0) begin
        qt = r / newR;
        tmp = t - qt * newT;
        t = newT;
        newT = tmp;
        tmp = r - qt * newR;
        r = newR;
        newR = tmp;
      end
    end
    if (t < 0) t = t + m;
    return t;
  endfunction

endpackage

// File: rtl/rnsPairOne.sv
`timescale 1ns/1ps
// Merges residues mod 2^Q-1 and 2^Q+1 into a value mod 2^(2Q)-1.
// x = rPlus + (2^Q+1)*k, k = (rMinus - rPlus) * 2^(Q-1) mod (2^Q-1).
module rnsPairOne #(
  parameter int Q = 4
) (
  input  logic [Q-1:0]   rMinus,
  input  logic [Q:0]     rPlus,
  output logic [2*Q-1:0] xOut
);
  logic [Q-1:0] plusRed;
  logic [Q:0]   rawSum;
  logic [Q-1:0] eacSum;
  logic [Q-1:0] rotSum;
  logic [Q-1:0] kVal;

  always_comb begin
    // 2^Q is congruent to 1 modulo 2^Q-1
    plusRed = rPlus[Q] ? {{(Q-1){1'b0}}, 1'b1} : rPlus[Q-1:0];
    // one's-complement subtraction with end-around carry
    rawSum  = {1'b0, rMinus} + {1'b0, ~plusRed};
    eacSum  = rawSum[Q-1:0] + {{(Q-1){1'b0}}, rawSum[Q]};
    // times 2^(Q-1) modulo 2^Q-1 is a rotation right by one
    rotSum  = {eacSum[0], eacSum[Q-1:1]};
    kVal    = (&rotSum) ? '0 : rotSum;
    xOut    = {{(Q-1){1'b0}}, rPlus}
            + {kVal, {Q{1'b0}}}
            + {{Q{1'b0}}, kVal};
  end
endmodule

// File: rtl/rnsPairThree.sv
`timescale 1ns/1ps
// Merges residues mod 2^Q-3 and 2^Q+3 into a value mod 2^(2Q)-9.
// x = rPlus + (2^Q+3)*k, k = (rMinus - rPlus) * inv(6) mod (2^Q-3).
module rnsPairThree #(
  parameter int Q = 4
) (
  input  logic [Q-1:0]   rMinus,
  input  logic [Q:0]     rPlus,
  output logic [2*Q-1:0] xOut
);
  localparam int MOD_I = (1 << Q) - 3;
  localparam int INV_I = rnsPkg::modInverse(6, MOD_I);
  localparam logic [Q-1:0] MOD_V = Q'(MOD_I);
  localparam logic [Q-1:0] INV_V = Q'(INV_I);

  logic [Q:0]     plusSub;
  logic [Q-1:0]   plusRed;
  logic [Q-1:0]   diff;
  logic [2*Q-1:0] term [Q];
  logic [2*Q-1:0] prod;
  logic [Q+1:0]   fold1;
  logic [Q:0]     fold2;
  logic [Q:0]     fold3;
  logic [Q:0]     foldSub;
  logic [Q-1:0]   kVal;

  always_comb begin
    plusSub = rPlus - {1'b0, MOD_V};
    plusRed = plusSub[Q] ? rPlus[Q-1:0] : plusSub[Q-1:0];
    diff    = (rMinus >= plusRed) ? (rMinus - plusRed) : (rMinus + (MOD_V - plusRed));
  end

  // constant inverse applied as a sum of shifted operands
  for (genvar gi = 0; gi < Q; gi++) begin : g_term
    assign term[gi] = INV_V[gi] ? ({{Q{1'b0}}, diff} << gi) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < Q; i++) prod = prod + term[i];
    // 2^Q is congruent to 3: fold the high part as (h<<1)+h
    fold1 = {2'b00, prod[Q-1:0]}
          + {1'b0, prod[2*Q-1:Q], 1'b0}
          + {2'b00, prod[2*Q-1:Q]};
    fold2 = {1'b0, fold1[Q-1:0]}
          + {{(Q-2){1'b0}}, fold1[Q+1:Q], 1'b0}
          + {{(Q-1){1'b0}}, fold1[Q+1:Q]};
    fold3 = {1'b0, fold2[Q-1:0]}
          + {{(Q-1){1'b0}}, fold2[Q], fold2[Q]};
    foldSub = fold3 - {1'b0, MOD_V};
    kVal    = foldSub[Q] ? fold3[Q-1:0] : foldSub[Q-1:0];
    xOut    = {{(Q-1){1'b0}}, rPlus}
            + {kVal, {Q{1'b0}}}
            + {{(Q-1){1'b0}}, kVal, 1'b0}
            + {{Q{1'b0}}, kVal};
  end
endmodule

// File: rtl/rnsFinalStage.sv
`timescale 1ns/1ps
// X = xB + (2^(2Q)-9)*k, k = (xA - xB) * inv(-8) mod (2^(2Q)-1)
//   = rotate-right-by-3 of (xB - xA) in one's complement.
module rnsFinalStage #(
  parameter int Q = 4
) (
  input  logic [2*Q-1:0] xA,
  input  logic [2*Q-1:0] xB,
  output logic [4*Q-1:0] value
);
  localparam int W = 2 * Q;

  logic [W:0]   rawSum;
  logic [W-1:0] eacSum;
  logic [W-1:0] rotSum;
  logic [W-1:0] kVal;

  always_comb begin
    rawSum = {1'b0, xB} + {1'b0, ~xA};
    eacSum = rawSum[W-1:0] + {{(W-1){1'b0}}, rawSum[W]};
    rotSum = {eacSum[2:0], eacSum[W-1:3]};
    kVal   = (&rotSum) ? '0 : rotSum;
    value  = {{W{1'b0}}, xB}
           + {kVal, {W{1'b0}}}
           - {{(W-3){1'b0}}, kVal, 3'b000}
           - {{W{1'b0}}, kVal};
  end
endmodule

// File: rtl/rnsControl.sv
`timescale 1ns/1ps
module rnsControl #(
  parameter bit PIPE_STAGE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output rnsPkg::rnsCtrlT ctrl
);
  logic validOut;

  if (PIPE_STAGE) begin : g_pipe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validOut <= 1'b0;
      else       validOut <= inValid;
    end
    // R2
    in_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> ctrl.outValid);
    // R6
    idle_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !ctrl.outValid);
  end else begin : g_comb
    assign validOut = inValid;
    // R3
    comb_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctrl.outValid |-> inValid);
  end

  assign ctrl = '{loadStage: inValid, outValid: validOut};
endmodule

// File: rtl/rnsDatapath.sv
`timescale 1ns/1ps
module rnsDatapath #(
  parameter int Q          = 4,
  parameter bit PIPE_STAGE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  rnsPkg::rnsCtrlT ctrl,
  input  logic [Q-1:0]    resMinusOne,
  input  logic [Q:0]      resPlusOne,
  input  logic [Q-1:0]    resMinusThree,
  input  logic [Q:0]      resPlusThree,
  output logic [4*Q-1:0]  result
);
  localparam int W = 2 * Q;
  localparam logic [4*Q+3:0] ONE_W  = 1;
  localparam logic [4*Q+3:0] MODA_W = (ONE_W << W) - ONE_W;
  localparam logic [4*Q+3:0] MODB_W = (ONE_W << W) - 9;
  localparam logic [4*Q+3:0] DYN_W  = MODA_W * MODB_W;
  localparam logic [W-1:0]   MODA   = MODA_W[W-1:0];
  localparam logic [W-1:0]   MODB   = MODB_W[W-1:0];

  logic [W-1:0] pairA;
  logic [W-1:0] pairB;
  logic [W-1:0] stageA;
  logic [W-1:0] stageB;

  rnsPairOne #(.Q(Q)) pairOne_i (
    .rMinus(resMinusOne),
    .rPlus (resPlusOne),
    .xOut  (pairA)
  );

  rnsPairThree #(.Q(Q)) pairThree_i (
    .rMinus(resMinusThree),
    .rPlus (resPlusThree),
    .xOut  (pairB)
  );

  if (PIPE_STAGE) begin : g_pipe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageA <= '0;
        stageB <= '0;
      end else if (ctrl.loadStage) begin
        stageA <= pairA;
        stageB <= pairB;
      end
    end
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !ctrl.loadStage |=> $stable(result));
  end else begin : g_comb
    assign stageA = pairA;
    assign stageB = pairB;
  end

  rnsFinalStage #(.Q(Q)) final_i (
    .xA   (stageA),
    .xB   (stageB),
    .value(result)
  );

  // R1
  xa_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageA < MODA);
  // R1
  xb_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageB < MODB);
  // R4
  result_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.outValid || ctrl.loadStage) |-> ({4'b0000, result} < DYN_W));
endmodule

// File: rtl/rnsReverseConverter.sv
`timescale 1ns/1ps
module rnsReverseConverter #(
  parameter int Q          = 4,
  parameter bit PIPE_STAGE = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [Q-1:0]   resMinusOne,
  input  logic [Q:0]     resPlusOne,
  input  logic [Q-1:0]   resMinusThree,
  input  logic [Q:0]     resPlusThree,
  output logic           outValid,
  output logic [4*Q-1:0] result
);
  rnsPkg::rnsCtrlT ctrl;

  rnsControl #(.PIPE_STAGE(PIPE_STAGE)) control_i (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .ctrl   (ctrl)
  );

  rnsDatapath #(.Q(Q), .PIPE_STAGE(PIPE_STAGE)) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .resMinusOne  (resMinusOne),
    .resPlusOne   (resPlusOne),
    .resMinusThree(resMinusThree),
    .resPlusThree (resPlusThree),
    .result       (result)
  );

  assign outValid = ctrl.outValid;
endmodule

// File: tb/rnsReverseConverter_tb_top.sv
`timescale 1ns/1ps
module rnsReverseConverter_tb_top;
  localparam int Q     = 4;
  localparam int MA    = (1 << Q) - 1;
  localparam int MB    = (1 << Q) + 1;
  localparam int MC    = (1 << Q) - 3;
  localparam int MD    = (1 << Q) + 3;
  localparam int RANGE = MA * MB * MC * MD;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0;
  logic [Q-1:0]   resMinusOne = '0;
  logic [Q:0]     resPlusOne = '0;
  logic [Q-1:0]   resMinusThree = '0;
  logic [Q:0]     resPlusThree = '0;
  logic           outValidP;
  logic [4*Q-1:0] resultP;
  logic           outValidC;
  logic [4*Q-1:0] resultC;

  int  testCount = 0;
  int  failCount = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  rnsReverseConverter #(.Q(Q), .PIPE_STAGE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .resMinusOne(resMinusOne), .resPlusOne(resPlusOne),
    .resMinusThree(resMinusThree), .resPlusThree(resPlusThree),
    .outValid(outValidP), .result(resultP)
  );

  rnsReverseConverter #(.Q(Q), .PIPE_STAGE(1'b0)) dut_comb_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .resMinusOne(resMinusOne), .resPlusOne(resPlusOne),
    .resMinusThree(resMinusThree), .resPlusThree(resPlusThree),
    .outValid(outValidC), .result(resultC)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic applyValue(input int x, input bit valid);
    resMinusOne   = Q'(x % MA);
    resPlusOne    = (Q+1)'(x % MB);
    resMinusThree = Q'(x % MC);
    resPlusThree  = (Q+1)'(x % MD);
    inValid       = valid;
  endtask

  function automatic string tagFor(input int x);
    if (x == 0 || x == RANGE - 1) return "R9";
    if (x % MB == MB - 1)         return "R5";
    return "R1";
  endfunction

  initial begin
    int prevX;
    bit havePrev;
    havePrev = 1'b0;
    prevX = 0;
    @(negedge clk);
    // R7 during reset
    check(outValidP == 1'b0, "R7", int'(outValidP), 0);
    check(resultP == '0, "R7", int'(resultP), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 after release, before any strobe
    check(outValidP == 1'b0, "R7", int'(outValidP), 0);
    check(resultP == '0, "R7", int'(resultP), 0);

    for (int x = 0; x < RANGE; x++) begin
      @(negedge clk);
      if (havePrev) begin
        // R2 / R8: previous value appears while the next is captured
        check(outValidP == 1'b1, "R8", int'(outValidP), 1);
        check(int'(resultP) == prevX, "R2", int'(resultP), prevX);
        check(int'(resultP) < RANGE, "R4", int'(resultP), RANGE - 1);
      end
      applyValue(x, 1'b1);
      #1;
      // R3 combinational mode plus R1/R5/R9 value checks
      check(outValidC == 1'b1, "R3", int'(outValidC), 1);
      check(int'(resultC) == x, tagFor(x), int'(resultC), x);
      prevX = x;
      havePrev = 1'b1;
      if (x % 97 == 50) begin
        @(negedge clk);
        check(outValidP == 1'b1, "R2", int'(outValidP), 1);
        check(int'(resultP) == prevX, tagFor(prevX), int'(resultP), prevX);
        applyValue((x * 7 + 1234) % RANGE, 1'b0);
        #1;
        check(outValidC == 1'b0, "R3", int'(outValidC), 0);
        @(negedge clk);
        // R6: no strobe, result held despite different residues
        check(outValidP == 1'b0, "R6", int'(outValidP), 0);
        check(int'(resultP) == prevX, "R6", int'(resultP), prevX);
        havePrev = 1'b0;
      end
    end
    @(negedge clk);
    if (havePrev) begin
      check(outValidP == 1'b1, "R9", int'(outValidP), 1);
      check(int'(resultP) == prevX, "R9", int'(resultP), prevX);
    end
    inValid = 1'b0;
    @(negedge clk);
    check(outValidP == 1'b0, "R6", int'(outValidP), 0);
    check(int'(resultP) == prevX, "R6", int'(resultP), prevX);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule